// File: doc/BRIEF.md
# Two-Thread Fetch Address Controller with Branch-Triggered Switching

This block produces the fetch address for a pipelined processor that interleaves two hardware threads at a coarse grain. Each thread keeps its own program counter. The thread that is fetching runs sequentially until a branch retires through the block. The branch then hands the fetch stream to the other thread. The branching thread later resumes at the branch target if the branch was taken, or at the sequential address if it was not.

Each cycle the pipeline presents one instruction descriptor: a valid flag, a branch flag, a delay-slot flag, the resolved condition and the target. The descriptor describes the instruction at the current fetch address. A branch's target and condition go into a single holding register. Nothing but a branch ever writes that register, and it keeps its value until the switch that uses it. A branch with a delay slot switches after its delay-slot instruction, and the held target is applied to the branching thread at that point. A branch without a delay slot switches at once, and its target is written into the branching thread's counter one cycle later. If the first instruction of the incoming thread is also a branch, the holding register is still busy, so the block raises a one-cycle stall and the pipeline presents that instruction again.

Top module: `thread_switch_fetch`

## Requirements
- R1: While reset is held and after it is released, both thread counters are 0, thread select is 0 and stall is low.
- R2: An accepted non-branch instruction that is not in a delay slot advances the fetch address by 4 and leaves thread select unchanged on the next cycle.
- R3: When `in_vld` is low, the fetch address and thread select keep their values, and a pending delay slot stays pending.
- R4: A branch with `in_ds`=1 is followed by a fetch at its address + 4 in the same thread (the delay slot). After the delay-slot instruction the other thread is selected. The branching thread later resumes at the target if taken, or at branch address + 8 if not.
- R5: A branch with `in_ds`=0 selects the other thread on the next cycle. The branching thread later resumes at the target if taken, or at branch address + 4 if not.
- R6: `stall` is high only in a cycle where a valid branch arrives directly after a branch with `in_ds`=0 caused a switch. A branch that follows a completed delay slot causes no stall.
- R7: During a stall cycle the fetch address and thread select hold. Stall lasts exactly one cycle, and the repeated instruction is then accepted.
- R8: The branch flag of an instruction in a delay slot is ignored. It neither switches thread nor replaces the held target.
- R9: `in_tk` and `in_tgt` of non-branch instructions never change where any thread resumes.
- R10: Thread select changes only after a completed delay slot or a branch with `in_ds`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | An instruction is presented this cycle |
| in_br | input | 1 | The instruction is a branch |
| in_ds | input | 1 | The branch has a delay slot |
| in_tk | input | 1 | Resolved branch condition (1 = taken) |
| in_tgt | input | AW (32) | Resolved branch target |
| fetch_pc | output | AW (32) | Fetch address of the selected thread |
| fetch_thr | output | 1 | Selected thread |
| stall | output | 1 | Hold the pipeline and present the instruction again |

## Verification
A wrong held target or a dropped commit stays hidden until the branching thread is selected again. At that point `fetch_pc` shows the wrong resume address, usually two to four cycles after the branch. A thread-select or delay-slot flag error shows in `fetch_thr` on the very next cycle. A stuck or missing commit flag shows as a missing or extra stall on the first branch after a switch. The directed scenarios therefore always hand control back to the branching thread, so that every resume address reaches the ports.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int NTHR = 2;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_SEQ,
    ACT_BR_DS,
    ACT_BR_ND,
    ACT_DSLOT,
    ACT_STALL
  } ts_act_e;
endpackage

// File: rtl/ts_switch_ctrl.sv
module ts_switch_ctrl
  import ts_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_vld,
  input  logic    in_br,
  input  logic    in_ds,
  input  logic    hold_vld,
  output ts_act_e act,
  output logic    cur_thr,
  output logic    ds_pend,
  output logic    stall
);
  logic thr_d, ds_d, thr_en, ds_en;

  always_comb begin
    if (!in_vld)                act = ACT_IDLE;
    else if (ds_pend)           act = ACT_DSLOT;
    else if (in_br && hold_vld) act = ACT_STALL;
    else if (in_br && in_ds)    act = ACT_BR_DS;
    else if (in_br)             act = ACT_BR_ND;
    else                        act = ACT_SEQ;
  end

  assign stall  = (act == ACT_STALL);
  assign thr_en = (act == ACT_DSLOT) || (act == ACT_BR_ND);
  assign thr_d  = ~cur_thr;
  assign ds_en  = (act == ACT_DSLOT) || (act == ACT_BR_DS);
  assign ds_d   = (act == ACT_BR_DS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_thr <= 1'b0;
      ds_pend <= 1'b0;
    end else begin
      if (thr_en) cur_thr <= thr_d;
      if (ds_en)  ds_pend <= ds_d;
    end
  end
endmodule

// File: rtl/ts_branch_hold.sv
module ts_branch_hold
  import ts_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ts_act_e       act,
  input  logic          cur_thr,
  input  logic          in_tk,
  input  logic [AW-1:0] in_tgt,
  output logic          hold_vld,
  output logic          hold_tk,
  output logic [AW-1:0] hold_tgt,
  output logic          cm_en,
  output logic          cm_thr
);
  logic cap_en, vld_d;

  assign cap_en = (act == ACT_BR_DS) || (act == ACT_BR_ND);
  assign vld_d  = (act == ACT_BR_ND);
  assign cm_en  = hold_vld && hold_tk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      hold_tk  <= 1'b0;
      hold_tgt <= '0;
      cm_thr   <= 1'b0;
    end else begin
      hold_vld <= vld_d;
      if (cap_en) begin
        hold_tk  <= in_tk;
        hold_tgt <= in_tgt;
        cm_thr   <= cur_thr;
      end
    end
  end
endmodule

// File: rtl/ts_pc_bank.sv
module ts_pc_bank
  import ts_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ts_act_e       act,
  input  logic          cur_thr,
  input  logic          cm_en,
  input  logic          cm_thr,
  input  logic          hold_tk,
  input  logic [AW-1:0] hold_tgt,
  output logic [AW-1:0] fetch_pc
);
  localparam logic [AW-1:0] INC = AW'(STEP);

  logic adv;
  assign adv = (act == ACT_SEQ) || (act == ACT_BR_DS) || (act == ACT_BR_ND);

  logic [AW-1:0] pc_sel [NTHR];

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [AW-1:0] pc_q, pc_d;
    logic          own, cm_hit, en;

    assign own    = (cur_thr == 1'(t));
    assign cm_hit = cm_en && (cm_thr == 1'(t));

    always_comb begin
      en   = 1'b1;
      pc_d = pc_q;
      if (cm_hit)                          pc_d = hold_tgt;
      else if (own && act == ACT_DSLOT)    pc_d = hold_tk ? hold_tgt : pc_q + INC;
      else if (own && adv)                 pc_d = pc_q + INC;
      else                                 en   = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pc_q <= '0;
      else if (en) pc_q <= pc_d;
    end

    assign pc_sel[t] = pc_q;
  end

  assign fetch_pc = pc_sel[cur_thr];
endmodule

// File: rtl/thread_switch_fetch.sv
module thread_switch_fetch
  import ts_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_br,
  input  logic          in_ds,
  input  logic          in_tk,
  input  logic [AW-1:0] in_tgt,
  output logic [AW-1:0] fetch_pc,
  output logic          fetch_thr,
  output logic          stall
);
  ts_act_e       act;
  logic          ds_pend, hold_vld, hold_tk, cm_en, cm_thr;
  logic [AW-1:0] hold_tgt;

  ts_switch_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_br(in_br), .in_ds(in_ds),
    .hold_vld(hold_vld), .act(act), .cur_thr(fetch_thr), .ds_pend(ds_pend),
    .stall(stall)
  );

  ts_branch_hold #(.AW(AW)) u_hold (
    .clk(clk), .rst_n(rst_n), .act(act), .cur_thr(fetch_thr), .in_tk(in_tk),
    .in_tgt(in_tgt), .hold_vld(hold_vld), .hold_tk(hold_tk),
    .hold_tgt(hold_tgt), .cm_en(cm_en), .cm_thr(cm_thr)
  );

  ts_pc_bank #(.AW(AW), .STEP(STEP)) u_pcs (
    .clk(clk), .rst_n(rst_n), .act(act), .cur_thr(fetch_thr), .cm_en(cm_en),
    .cm_thr(cm_thr), .hold_tk(hold_tk), .hold_tgt(hold_tgt),
    .fetch_pc(fetch_pc)
  );
endmodule

// File: rtl/ts_chk.sv
module ts_chk #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic          in_br,
  input logic          in_ds,
  input logic [AW-1:0] fetch_pc,
  input logic          fetch_thr,
  input logic          stall,
  input logic          ds_pend,
  input logic          hold_vld
);
  // R6
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (in_vld && in_br && hold_vld));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(fetch_pc) && $stable(fetch_thr) && !stall));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(fetch_pc) && $stable(fetch_thr)));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_br && !ds_pend) |=>
      (fetch_pc == $past(fetch_pc) + AW'(STEP) && $stable(fetch_thr)));

  // R10
  thr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fetch_thr) |->
      $past(in_vld && !stall && (ds_pend || (in_br && !in_ds))));

  // R8
  dslot_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_pend |-> !stall);
endmodule

bind thread_switch_fetch ts_chk #(.AW(AW), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_br(in_br), .in_ds(in_ds),
  .fetch_pc(fetch_pc), .fetch_thr(fetch_thr), .stall(stall),
  .ds_pend(ds_pend), .hold_vld(hold_vld)
);

// File: tb/thread_switch_fetch_bench.sv
`timescale 1ns/1ps
module thread_switch_fetch_bench;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_vld, in_br, in_ds, in_tk;
  logic [AW-1:0] in_tgt;
  logic [AW-1:0] fetch_pc;
  logic          fetch_thr, stall;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  thread_switch_fetch #(.AW(AW), .STEP(4)) u_thread_switch_fetch (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_br(in_br), .in_ds(in_ds),
    .in_tk(in_tk), .in_tgt(in_tgt), .fetch_pc(fetch_pc),
    .fetch_thr(fetch_thr), .stall(stall)
  );

  task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one descriptor, then check state and stall away from the edge
  task automatic cyc(string req, logic v, logic b, logic d, logic t,
                     logic [AW-1:0] g, logic [AW-1:0] e_pc, logic e_thr, logic e_st);
    @(negedge clk);
    in_vld = v; in_br = b; in_ds = d; in_tk = t; in_tgt = g;
    #1;
    chk(req, "fetch_pc", fetch_pc, e_pc);
    chk(req, "fetch_thr", AW'(fetch_thr), AW'(e_thr));
    chk(req, "stall", AW'(stall), AW'(e_st));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_vld = 0; in_br = 0; in_ds = 0; in_tk = 0; in_tgt = '0;
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "fetch_pc in reset", fetch_pc, '0);
    chk("R1", "fetch_thr in reset", AW'(fetch_thr), '0);
    chk("R1", "stall in reset", AW'(stall), '0);
    rst_n = 1'b1;
  endtask

  task automatic t_seq_bubble();
    do_reset();
    cyc("R1", 0, 0, 0, 0, '0, 32'h0, 0, 0);
    cyc("R2", 1, 0, 0, 0, '0, 32'h0, 0, 0);
    cyc("R2", 1, 0, 0, 1, 32'h55, 32'h4, 0, 0);
    cyc("R3", 0, 0, 0, 0, '0, 32'h8, 0, 0);
    cyc("R3", 1, 0, 0, 0, '0, 32'h8, 0, 0);
    cyc("R2", 0, 0, 0, 0, '0, 32'hC, 0, 0);
  endtask

  task automatic t_dslot_taken();
    do_reset();
    cyc("R2", 1, 0, 0, 0, '0, 32'h0, 0, 0);
    cyc("R2", 1, 0, 0, 0, '0, 32'h4, 0, 0);
    cyc("R4", 1, 1, 1, 1, 32'h100, 32'h8, 0, 0);
    // delay slot carrying a branch flag: R8 says it is ignored
    cyc("R8", 1, 1, 0, 1, 32'h999, 32'hC, 0, 0);
    cyc("R10", 1, 0, 0, 1, 32'hDEAD, 32'h0, 1, 0);
    cyc("R5", 1, 1, 0, 0, 32'h777, 32'h4, 1, 0);
    cyc("R4", 1, 0, 0, 1, 32'hBEEF, 32'h100, 0, 0);
    cyc("R5", 1, 1, 0, 0, '0, 32'h104, 0, 0);
    cyc("R5", 0, 0, 0, 0, '0, 32'h8, 1, 0);
  endtask

  task automatic t_b2b_nods();
    do_reset();
    cyc("R5", 1, 1, 0, 1, 32'h40, 32'h0, 0, 0);
    cyc("R6", 1, 1, 0, 1, 32'h80, 32'h0, 1, 1);
    cyc("R7", 1, 1, 0, 1, 32'h80, 32'h0, 1, 0);
    cyc("R9", 1, 0, 0, 1, 32'hBAD, 32'h40, 0, 0);
    cyc("R2", 1, 1, 0, 0, '0, 32'h44, 0, 0);
    cyc("R9", 0, 0, 0, 0, '0, 32'h80, 1, 0);
    cyc("R3", 0, 0, 0, 0, '0, 32'h80, 1, 0);
  endtask

  task automatic t_b2b_second_ds();
    do_reset();
    cyc("R5", 1, 1, 0, 1, 32'h20, 32'h0, 0, 0);
    cyc("R6", 1, 1, 1, 1, 32'h60, 32'h0, 1, 1);
    cyc("R7", 1, 1, 1, 1, 32'h60, 32'h0, 1, 0);
    cyc("R4", 1, 0, 0, 0, '0, 32'h4, 1, 0);
    cyc("R5", 1, 0, 0, 0, '0, 32'h20, 0, 0);
    cyc("R2", 1, 1, 0, 0, '0, 32'h24, 0, 0);
    cyc("R4", 0, 0, 0, 0, '0, 32'h60, 1, 0);
  endtask

  task automatic t_ds_then_branch();
    do_reset();
    cyc("R4", 1, 1, 1, 1, 32'h30, 32'h0, 0, 0);
    cyc("R4", 1, 0, 0, 0, '0, 32'h4, 0, 0);
    cyc("R6", 1, 1, 0, 1, 32'h50, 32'h0, 1, 0);
    cyc("R6", 1, 1, 0, 1, 32'h90, 32'h30, 0, 1);
    cyc("R7", 1, 1, 0, 1, 32'h90, 32'h30, 0, 0);
    cyc("R5", 0, 0, 0, 0, '0, 32'h50, 1, 0);
    cyc("R4", 1, 1, 1, 0, 32'h444, 32'h50, 1, 0);
    cyc("R3", 0, 0, 0, 0, '0, 32'h54, 1, 0);
    cyc("R4", 1, 0, 0, 0, '0, 32'h54, 1, 0);
    cyc("R5", 0, 0, 0, 0, '0, 32'h90, 0, 0);
    cyc("R5", 1, 1, 0, 0, '0, 32'h90, 0, 0);
    cyc("R4", 0, 0, 0, 0, '0, 32'h58, 1, 0);
  endtask

  logic done = 1'b0;

  initial begin
    rst_n = 1'b0;
    in_vld = 0; in_br = 0; in_ds = 0; in_tk = 0; in_tgt = '0;
    t_seq_bubble();
    t_dslot_taken();
    t_b2b_nods();
    t_b2b_second_ds();
    t_ds_then_branch();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule